// File: doc/BRIEF.md
# Start-Stop Count Gate Sequencer

This block decides when a counting instrument is actually measuring. Conditioned input pulses enter on one pin, and the sequencer watches for their rising edges. Each accepted edge passes through a delay of a fixed number of clock cycles. The delay lets the time-base scalers and the coincidence detector settle before the sequencer acts. A delayed pulse that arrives while the function select allows it clocks a two-stage state counter.

The first such pulse after reset opens the measurement gate. The open gate drives two enables: one for the time-base divider and one for the totalizer. The gate stays open until the time base reports coincidence. From that point both enables are off and the sequencer is armed. The next admitted delayed pulse then moves the sequencer into a done state and emits a single-cycle strobe that latches the display. The done state is held until reset, which returns the sequencer to idle from any state.

Top module: `gate_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sampled cycle after it, `state_o` is 2'b00 and `tb_gate_o`, `tot_gate_o` and `disp_strobe_o` are all 0.
- R2: A rising edge of `pulse_i` sampled at clock edge e, accepted while in state 00, changes `state_o` to 2'b01 at edge e+DELAY_CYC, provided `func_en_i` is 1 in the cycle before that edge. Before that edge the state stays 2'b00.
- R3: `tb_gate_o` and `tot_gate_o` are equal at all times. They are 1 exactly while the state is 2'b01 and no coincidence has been latched.
- R4: The delay cannot be retriggered. A rising edge that arrives while a delay is still running is discarded and never produces a delayed pulse.
- R5: A delayed pulse that completes while `func_en_i` is 0 is dropped and leaves the state unchanged.
- R6: In state 01, before any coincidence has been latched, delayed pulses leave the state and the gates unchanged.
- R7: `coin_i` sampled high at edge c in state 01 makes both gates 0 after edge c. They stay 0 after `coin_i` falls.
- R8: Once coincidence has been latched, the next admitted delayed pulse changes the state to 2'b11. `disp_strobe_o` is 1 for exactly the one cycle after that edge.
- R9: State 2'b11 holds until reset. Further pulses and coincidence have no effect on it, and they raise no further strobe.
- R10: `coin_i` while in state 00 is ignored. A gate opened afterwards stays open.
- R11: Reset sampled in state 01 or 11 returns the state to 2'b00 with both gates 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_i | input | 1 | Conditioned input pulse stream. Rising edges are used |
| coin_i | input | 1 | Coincidence from the time base, active high |
| func_en_i | input | 1 | Function select. 1 lets delayed pulses reach the state counter |
| tb_gate_o | output | 1 | Time-base gate enable |
| tot_gate_o | output | 1 | Totalizer gate enable |
| disp_strobe_o | output | 1 | One-cycle display latch strobe on entry to done |
| state_o | output | 2 | Sequencer state: 00 idle, 01 gate open, 11 done |

## Verification
The bench builds the block with DELAY_CYC set to 5, a much shorter delay than the default. This keeps every delay window a few cycles long, so an expectation can be placed on the exact edge where the state moves and on the edge just before it. The short window also lets a second pulse be placed inside a running delay. That pulse is timed so that, if the delay were retriggerable, it would complete after the function select has returned to 1 and would wrongly open the gate. The same window holds the dropped-by-function-select case.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [1:0] {
        GS_IDLE = 2'b00,
        GS_OPEN = 2'b01,
        GS_DONE = 2'b11
    } gs_state_e;

endpackage

// File: rtl/gs_edge_det.sv
module gs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/gs_delay.sv
module gs_delay #(
    parameter int DELAY_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic fire_o
);

    generate
        if (DELAY_CYC == 0) begin : g_bypass
            assign fire_o = trig_i;
        end else begin : g_count
            localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
            localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_CYC - 1);

            typedef struct packed {
                logic             busy;
                logic [CNT_W-1:0] cnt;
            } dly_regs_t;

            dly_regs_t r_d, r_q;

            always_comb begin
                r_d    = r_q;
                fire_o = r_q.busy && (r_q.cnt == '0);
                if (r_q.busy) begin
                    if (r_q.cnt == '0) r_d.busy = 1'b0;
                    else               r_d.cnt  = r_q.cnt - 1'b1;
                end else if (trig_i) begin
                    r_d.busy = 1'b1;
                    r_d.cnt  = LOAD;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) r_q <= '0;
                else        r_q <= r_d;
            end
        end
    endgenerate

endmodule

// File: rtl/gs_fsm.sv
module gs_fsm
    import gs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       coin_i,
    output logic [1:0] state_o,
    output logic       gate_o,
    output logic       strobe_o
);

    typedef struct packed {
        gs_state_e st;
        logic      armed;
        logic      strobe;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.strobe = 1'b0;
        case (r_q.st)
            GS_IDLE: begin
                r_d.armed = 1'b0;
                if (step_i) r_d.st = GS_OPEN;
            end
            GS_OPEN: begin
                if (step_i && r_q.armed) begin
                    r_d.st     = GS_DONE;
                    r_d.strobe = 1'b1;
                    r_d.armed  = 1'b0;
                end else if (coin_i) begin
                    r_d.armed = 1'b1;
                end
            end
            GS_DONE: begin
                r_d.st = GS_DONE;
            end
            default: begin
                r_d.st    = GS_IDLE;
                r_d.armed = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= GS_IDLE;
            r_q.armed  <= 1'b0;
            r_q.strobe <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o  = r_q.st;
    assign gate_o   = (r_q.st == GS_OPEN) && !r_q.armed;
    assign strobe_o = r_q.strobe;

endmodule

// File: rtl/gate_seq.sv
module gate_seq #(
    parameter int DELAY_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_i,
    input  logic       coin_i,
    input  logic       func_en_i,
    output logic       tb_gate_o,
    output logic       tot_gate_o,
    output logic       disp_strobe_o,
    output logic [1:0] state_o
);

    logic rise, fired, step, gate;

    gs_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pulse_i),
        .rise_o  (rise)
    );

    gs_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (rise),
        .fire_o (fired)
    );

    assign step = fired & func_en_i;

    gs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .coin_i   (coin_i),
        .state_o  (state_o),
        .gate_o   (gate),
        .strobe_o (disp_strobe_o)
    );

    assign tb_gate_o  = gate;
    assign tot_gate_o = gate;

endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tb_gate_o,
    input logic       tot_gate_o,
    input logic       disp_strobe_o,
    input logic [1:0] state_o
);

    // R3
    gate_only_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_gate_o || tot_gate_o) |-> (state_o == 2'b01));

    // R7
    gate_stays_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01 && !tb_gate_o) |=> !tb_gate_o);

    // R8
    strobe_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_strobe_o) |-> (state_o == 2'b11));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_strobe_o |=> !disp_strobe_o);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11) |=> (state_o == 2'b11));

    // R2
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00) |=> (state_o != 2'b11));

endmodule

bind gate_seq gate_seq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tb_gate_o     (tb_gate_o),
    .tot_gate_o    (tot_gate_o),
    .disp_strobe_o (disp_strobe_o),
    .state_o       (state_o)
);

// File: tb/gate_seq_tb_top.sv
module gate_seq_tb_top;

    localparam int D = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_i = 1'b0;
    logic       coin_i = 1'b0;
    logic       func_en_i = 1'b1;
    logic       tb_gate_o, tot_gate_o, disp_strobe_o;
    logic [1:0] state_o;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    typedef struct {
        int         at;
        logic [1:0] st;
        logic       gate;
        logic       strb;
        string      tag;
    } exp_t;

    exp_t sbq[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    gate_seq #(.DELAY_CYC(D)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pulse_i       (pulse_i),
        .coin_i        (coin_i),
        .func_en_i     (func_en_i),
        .tb_gate_o     (tb_gate_o),
        .tot_gate_o    (tot_gate_o),
        .disp_strobe_o (disp_strobe_o),
        .state_o       (state_o)
    );

    task automatic expect_at(int at, logic [1:0] st, logic g, logic sb, string tag);
        exp_t e;
        e.at = at; e.st = st; e.gate = g; e.strb = sb; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: compares outputs against queued items at mid-cycle.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if (state_o !== e.st || tb_gate_o !== e.gate || tot_gate_o !== e.gate
                || disp_strobe_o !== e.strb) begin
                n_err++;
                $display("FAIL %s cyc=%0d: got st=%b tb=%b tot=%b strb=%b, exp st=%b gate=%b strb=%b",
                         e.tag, cyc, state_o, tb_gate_o, tot_gate_o, disp_strobe_o,
                         e.st, e.gate, e.strb);
            end
        end
    end

    // Driver: one-cycle pulse; returns the edge that samples its rise.
    task automatic send_pulse(output int e);
        @(negedge clk);
        e = cyc + 1;
        pulse_i = 1'b1;
        @(negedge clk);
        pulse_i = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        int e, e2;
        // R1: reset state
        @(negedge clk);
        expect_at(cyc + 1, 2'b00, 1'b0, 1'b0, "R1");
        idle(2);
        rst_n = 1'b1;
        expect_at(cyc + 1, 2'b00, 1'b0, 1'b0, "R1");
        idle(2);

        // R10: coincidence while idle is ignored
        coin_i = 1'b1;
        idle(1);
        coin_i = 1'b0;
        expect_at(cyc + 1, 2'b00, 1'b0, 1'b0, "R10");
        idle(2);

        // R5 + R4: dropped pulse, second pulse inside its delay discarded
        func_en_i = 1'b0;
        send_pulse(e);
        send_pulse(e2);
        while (cyc < e + D) @(negedge clk);
        func_en_i = 1'b1;
        expect_at(e + D + 1, 2'b00, 1'b0, 1'b0, "R5");
        expect_at(e2 + D + 2, 2'b00, 1'b0, 1'b0, "R4");
        idle(D + 4);

        // R2: start pulse opens the gate after exactly D edges
        send_pulse(e);
        expect_at(e + D - 1, 2'b00, 1'b0, 1'b0, "R2");
        expect_at(e + D, 2'b01, 1'b1, 1'b0, "R2");
        expect_at(e + D + 1, 2'b01, 1'b1, 1'b0, "R3");
        idle(D + 3);

        // R6 (and R10 follow-through): pulse while open without coincidence
        send_pulse(e);
        expect_at(e + D + 1, 2'b01, 1'b1, 1'b0, "R6");
        expect_at(e + D + 2, 2'b01, 1'b1, 1'b0, "R10");
        idle(D + 4);

        // R7: coincidence closes both gates and stays latched
        @(negedge clk);
        coin_i = 1'b1;
        e = cyc + 1;
        expect_at(e - 1 + 1, 2'b01, 1'b0, 1'b0, "R7");
        @(negedge clk);
        coin_i = 1'b0;
        expect_at(e + 3, 2'b01, 1'b0, 1'b0, "R7");
        idle(5);

        // R8: next delayed pulse moves to done with one strobe
        send_pulse(e);
        expect_at(e + D - 1, 2'b01, 1'b0, 1'b0, "R8");
        expect_at(e + D, 2'b11, 1'b0, 1'b1, "R8");
        expect_at(e + D + 1, 2'b11, 1'b0, 1'b0, "R8");
        idle(D + 3);

        // R9: done holds, no further strobe
        coin_i = 1'b1;
        send_pulse(e);
        coin_i = 1'b0;
        expect_at(e + D, 2'b11, 1'b0, 1'b0, "R9");
        expect_at(e + D + 1, 2'b11, 1'b0, 1'b0, "R9");
        idle(D + 4);

        // R11: reset from done
        rst_n = 1'b0;
        expect_at(cyc + 1, 2'b00, 1'b0, 1'b0, "R11");
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R11: reset from open
        send_pulse(e);
        expect_at(e + D, 2'b01, 1'b1, 1'b0, "R2");
        idle(D + 2);
        rst_n = 1'b0;
        expect_at(cyc + 1, 2'b00, 1'b0, 1'b0, "R11");
        idle(2);
        rst_n = 1'b1;
        idle(3);

        if (sbq.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL scoreboard: got %0d pending items, exp 0", sbq.size());
        end
        finish_run();
    end

endmodule